// File: doc/BRIEF.md
# Low-Power Mode and Stop-Clock Controller

This block holds one control register that decides how the chip behaves when the processor executes a STOP instruction. The register has three fields. The first names the low-power mode to enter. The second gives a stop depth, which says how far the clock and power resources are shut down in STOP mode. The third is a standby choice for the voltage regulator. A strobe from the core commits the register contents at the moment STOP executes. A wakeup input then brings the chip back to normal running, and it re-enables the resources in a fixed order, one cycle apart.

The resources are gated in a fixed order. The clock output goes first, then the PLL, then the oscillator. At the deepest level the power manager also drops into its low-power option. The system clocks are always stopped in STOP mode. The RUN, DOZE and WAIT selections only halt the core and gate nothing. A power-down request latches the regulator mode: pseudo-standby keeps low-voltage detection alive, and plain standby does not. The standby bit only counts when the reset controller's low-voltage-detect enable is set.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `core_halt` is 0, `mode_out` is 00, all four gate enables are 1, and `pmm_lp` and `vreg_pseudo` are 0.
- R2: A write with `reg_wr` high updates the register, and `reg_rdata` shows it from the next cycle. Bits [7:6] hold the mode, bits [4:3] the stop depth and bit 1 the standby choice. Bits 5, 2 and 0 always read as 0.
- R3: When `stop_exec` is seen while running, the current mode field is copied to `mode_out` and `core_halt` is set, both from the next cycle. The mode codes are 11 STOP, 10 WAIT, 01 DOZE and 00 RUN. A write in the same cycle as `stop_exec` does not change the mode or depth that is entered.
- R4: In STOP mode `sys_clk_en` is 0. Stop depth 00 keeps the other enables at 1. Depth 01 also clears `clkout_en`. Depth 10 clears `clkout_en` and `pll_en`. Depth 11 clears all three and sets `pmm_lp`.
- R5: While halted in RUN, DOZE or WAIT, all four gate enables stay 1 and `pmm_lp` stays 0.
- R6: Writes while halted still update `reg_rdata`, but they do not change `mode_out` or any gate enable.
- R7: When `wake` is seen in STOP mode, the wake-up runs in three steps. After the first edge `osc_en` is 1 and `pmm_lp` is 0. After the second, `pll_en` is 1. After the third, `clkout_en` and `sys_clk_en` are 1, `core_halt` is 0 and `mode_out` is 00.
- R8: When `wake` is seen while halted in RUN, DOZE or WAIT, the controller is running again after one edge.
- R9: `stop_exec` has no effect while halted or waking, and `wake` has no effect while running.
- R10: When `pwrdn_req` is high at an edge, `vreg_pseudo` takes the AND of the register's standby bit and `lvd_en` at that edge. Otherwise `vreg_pseudo` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| stop_exec | input | 1 | Core executed STOP |
| wake | input | 1 | Wakeup request |
| pwrdn_req | input | 1 | Power-down request |
| lvd_en | input | 1 | Low-voltage-detect enable from reset control |
| core_halt | output | 1 | Core halted in a low-power mode |
| mode_out | output | 2 | Active low-power mode code |
| sys_clk_en | output | 1 | System clock gate enable |
| clkout_en | output | 1 | Clock output gate enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| pmm_lp | output | 1 | Power manager low-power option |
| vreg_pseudo | output | 1 | Regulator mode: 1 pseudo-standby, 0 standby |

## Verification
The main collision is a register write that lands in the same cycle as the STOP strobe. The write must not leak into the mode or depth being entered, yet it must still show on the next read. A directed case writes a shallow setting while a deep STOP is being entered. The gate enables must follow the older deep setting, while `reg_rdata` shows the new value. The random phase raises writes, STOP strobes, wakeups and power-down requests on independent odds, so these coincide often, including a power-down request on the same edge as a write to the standby bit. A bench reference model judges every cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int REG_W    = 8;
  localparam int MODE_LSB = 6;
  localparam int MODE_W   = 2;
  localparam int NUM_RES  = 3;  // gated in order: 0 clkout, 1 pll, 2 osc
  localparam int STOP_W   = $clog2(NUM_RES + 1);
  localparam int STOP_LSB = 3;
  localparam int STBY_BIT = 1;
  localparam int STEP_W   = (NUM_RES > 2) ? $clog2(NUM_RES) : 1;
  localparam logic [REG_W-1:0] RW_MASK =
    REG_W'(((1 << MODE_W) - 1) << MODE_LSB) |
    REG_W'(((1 << STOP_W) - 1) << STOP_LSB) |
    REG_W'(1 << STBY_BIT);

  typedef enum logic [MODE_W-1:0] {
    LPM_RUN  = 2'b00,
    LPM_DOZE = 2'b01,
    LPM_WAIT = 2'b10,
    LPM_STOP = 2'b11
  } lp_mode_e;

  typedef enum logic [1:0] {
    SQ_ACTIVE = 2'd0,
    SQ_LOWP   = 2'd1,
    SQ_WAKE   = 2'd2
  } seq_st_e;
endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output lp_mode_e          mode_fld,
  output logic [STOP_W-1:0] stop_fld,
  output logic              stby_bit
);
  logic [REG_W-1:0] cfg_q;
  logic [REG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = wdata & RW_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign rdata    = cfg_q;
  assign mode_fld = lp_mode_e'(cfg_q[MODE_LSB +: MODE_W]);
  assign stop_fld = cfg_q[STOP_LSB +: STOP_W];
  assign stby_bit = cfg_q[STBY_BIT];

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata == ($past(wdata) & RW_MASK))); // R2
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_exec,
  input  logic              wake,
  input  lp_mode_e          mode_fld,
  input  logic [STOP_W-1:0] stop_fld,
  output seq_st_e           st,
  output lp_mode_e          lp_mode,
  output logic [STOP_W-1:0] stop_cfg,
  output logic [STEP_W-1:0] wk_step
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_RES - 1);

  seq_st_e           st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  lp_mode_e          mode_q;
  logic [STOP_W-1:0] cfg_q;
  logic              cap_en;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    cap_en = 1'b0;
    unique case (st_q)
      SQ_ACTIVE: if (stop_exec) begin
        st_d   = SQ_LOWP;
        cap_en = 1'b1;
      end
      SQ_LOWP: if (wake) begin
        if (mode_q == LPM_STOP) begin
          st_d   = SQ_WAKE;
          step_d = STEP_W'(1);
        end else begin
          st_d   = SQ_ACTIVE;
        end
      end
      SQ_WAKE: begin
        if (step_q == LAST_STEP) begin
          st_d   = SQ_ACTIVE;
          step_d = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: begin
        st_d   = SQ_ACTIVE;
        step_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_ACTIVE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LPM_RUN;
      cfg_q  <= '0;
    end else if (cap_en) begin
      mode_q <= mode_fld;
      cfg_q  <= stop_fld;
    end
  end

  assign st       = st_q;
  assign lp_mode  = mode_q;
  assign stop_cfg = cfg_q;
  assign wk_step  = step_q;

  AST_STOP_IGNORED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_ACTIVE) |=> ($stable(mode_q) && $stable(cfg_q))); // R9
  AST_WAKE_IGNORED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ACTIVE && !stop_exec) |=> (st_q == SQ_ACTIVE)); // R9
endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
  import lpm_pkg::*;
(
  input  seq_st_e            st,
  input  lp_mode_e           lp_mode,
  input  logic [STOP_W-1:0]  stop_cfg,
  input  logic [STEP_W-1:0]  wk_step,
  output logic               sys_clk_en,
  output logic [NUM_RES-1:0] res_en,
  output logic               pmm_lp
);
  logic in_stop;

  assign in_stop    = (st != SQ_ACTIVE) && (lp_mode == LPM_STOP);
  assign sys_clk_en = !in_stop;
  assign pmm_lp     = (st == SQ_LOWP) && (lp_mode == LPM_STOP) &&
                      (stop_cfg == STOP_W'(NUM_RES));

  for (genvar i = 0; i < NUM_RES; i++) begin : g_res
    logic cut_by_cfg;
    logic released;
    assign cut_by_cfg = (int'(stop_cfg) > i);
    assign released   = (st == SQ_WAKE) && (int'(wk_step) >= (NUM_RES - i));
    assign res_en[i]  = !(in_stop && cut_by_cfg && !released);
  end
endmodule

// File: rtl/lpm_vreg_sel.sv
module lpm_vreg_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn_req,
  input  logic stby_bit,
  input  logic lvd_en,
  output logic vreg_pseudo
);
  logic sel_q;
  logic sel_d;

  always_comb begin
    sel_d = stby_bit & lvd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= 1'b0;
    else if (pwrdn_req) sel_q <= sel_d;
  end

  assign vreg_pseudo = sel_q;

  AST_VREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwrdn_req) |-> $stable(vreg_pseudo)); // R10
  AST_VREG_NEEDS_LVD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vreg_pseudo) |-> $past(lvd_en)); // R10
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       stop_exec,
  input  logic       wake,
  input  logic       pwrdn_req,
  input  logic       lvd_en,
  output logic       core_halt,
  output logic [1:0] mode_out,
  output logic       sys_clk_en,
  output logic       clkout_en,
  output logic       pll_en,
  output logic       osc_en,
  output logic       pmm_lp,
  output logic       vreg_pseudo
);
  logic               rst_meta, rst_sync_n;
  lp_mode_e           mode_fld, lp_mode;
  logic [STOP_W-1:0]  stop_fld, stop_cfg;
  logic               stby_bit;
  seq_st_e            st;
  logic [STEP_W-1:0]  wk_step;
  logic [NUM_RES-1:0] res_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  lpm_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode_fld(mode_fld), .stop_fld(stop_fld), .stby_bit(stby_bit)
  );

  lpm_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .stop_exec(stop_exec), .wake(wake),
    .mode_fld(mode_fld), .stop_fld(stop_fld), .st(st), .lp_mode(lp_mode),
    .stop_cfg(stop_cfg), .wk_step(wk_step)
  );

  lpm_gate_dec u_dec (
    .st(st), .lp_mode(lp_mode), .stop_cfg(stop_cfg), .wk_step(wk_step),
    .sys_clk_en(sys_clk_en), .res_en(res_en), .pmm_lp(pmm_lp)
  );

  lpm_vreg_sel u_vreg (
    .clk(clk), .rst_n(rst_sync_n), .pwrdn_req(pwrdn_req), .stby_bit(stby_bit),
    .lvd_en(lvd_en), .vreg_pseudo(vreg_pseudo)
  );

  assign core_halt = (st != SQ_ACTIVE);
  assign mode_out  = core_halt ? lp_mode : LPM_RUN;
  assign clkout_en = res_en[0];
  assign pll_en    = res_en[1];
  assign osc_en    = res_en[2];

  AST_STOP_SYS_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (core_halt && mode_out == LPM_STOP) |-> !sys_clk_en); // R4
  AST_SHALLOW_ALL_ON: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (core_halt && mode_out != LPM_STOP) |->
      (sys_clk_en && clkout_en && pll_en && osc_en && !pmm_lp)); // R5
  AST_PLL_AFTER_OSC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pll_en) |-> (osc_en && $past(osc_en))); // R7
  AST_SYS_AFTER_PLL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sys_clk_en) |-> (pll_en && $past(pll_en))); // R7
endmodule

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, stop_exec, wake, pwrdn_req, lvd_en;
  logic [7:0] reg_wdata, reg_rdata;
  logic core_halt, sys_clk_en, clkout_en, pll_en, osc_en, pmm_lp, vreg_pseudo;
  logic [1:0] mode_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string ctx = "reset";

  always #5 clk = ~clk;

  lpm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .stop_exec(stop_exec), .wake(wake),
    .pwrdn_req(pwrdn_req), .lvd_en(lvd_en), .core_halt(core_halt),
    .mode_out(mode_out), .sys_clk_en(sys_clk_en), .clkout_en(clkout_en),
    .pll_en(pll_en), .osc_en(osc_en), .pmm_lp(pmm_lp), .vreg_pseudo(vreg_pseudo)
  );

  // Reference model: 0 running, 1 halted, 2 and 3 wake steps
  logic [7:0] m_reg;
  int         m_st;
  logic [1:0] m_mode, m_cfg;
  logic       m_vreg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 8'h00; m_st = 0; m_mode = 2'b00; m_cfg = 2'b00; m_vreg = 1'b0;
    end else begin
      if (pwrdn_req) m_vreg = m_reg[1] & lvd_en;
      case (m_st)
        0: if (stop_exec) begin m_st = 1; m_mode = m_reg[7:6]; m_cfg = m_reg[4:3]; end
        1: if (wake) m_st = (m_mode == 2'b11) ? 2 : 0;
        2: m_st = 3;
        default: m_st = 0;
      endcase
      if (reg_wr) m_reg = reg_wdata & 8'hDA;
    end
  end

  function automatic logic [4:0] exp_gates();
    logic stp;
    stp = (m_st != 0) && (m_mode == 2'b11);
    exp_gates[4] = !stp;                                  // sys
    exp_gates[3] = !stp || (m_cfg == 2'd0);               // clkout
    exp_gates[2] = !stp || (m_cfg < 2'd2) || (m_st == 3); // pll
    exp_gates[1] = !stp || (m_cfg != 2'd3) || (m_st >= 2);// osc
    exp_gates[0] = stp && (m_st == 1) && (m_cfg == 2'd3); // pmm
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) act=%h exp=%h", tag, ctx, act, exp);
    end
  endtask

  task automatic check_all();
    string gt;
    gt = (m_st >= 2) ? "R7" : ((m_st == 1 && m_mode == 2'b11) ? "R4" : "R5");
    chk("R2", reg_rdata, m_reg);
    chk("R3", {5'd0, core_halt, mode_out}, {5'd0, logic'(m_st != 0), (m_st != 0) ? m_mode : 2'b00});
    chk(gt, {3'd0, sys_clk_en, clkout_en, pll_en, osc_en, pmm_lp}, {3'd0, exp_gates()});
    chk("R10", {7'd0, vreg_pseudo}, {7'd0, m_vreg});
  endtask

  task automatic step(logic wr, logic [7:0] wd, logic stp, logic wk, logic pd);
    reg_wr = wr; reg_wdata = wd; stop_exec = stp; wake = wk; pwrdn_req = pd;
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [7:0] gates4();
    return {4'd0, sys_clk_en, clkout_en, pll_en, osc_en};
  endfunction

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] wd;
    logic [7:0] held;
    void'($urandom(32'd48213));
    rst_n = 1'b0; reg_wr = 0; reg_wdata = 0; stop_exec = 0; wake = 0;
    pwrdn_req = 0; lvd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0);

    // R1 reset state
    chk("R1", reg_rdata, 8'h00);
    chk("R1", {5'd0, core_halt, mode_out}, 8'h00);
    chk("R1", gates4(), 8'h0F);
    chk("R1", {6'd0, pmm_lp, vreg_pseudo}, 8'h00);

    // R4/R6/R7 every stop depth, reserved bits written as 1
    for (int c = 0; c < 4; c++) begin
      ctx = "R4";
      step(1, 8'hC0 | 8'(c << 3) | 8'h25, 0, 0, 0);
      step(0, 0, 1, 0, 0);
      chk("R4", gates4(), 8'h07 >> c);
      chk("R4", {7'd0, pmm_lp}, {7'd0, logic'(c == 3)});
      held = gates4();
      ctx = "R6";
      step(1, 8'h08, 0, 0, 0);
      chk("R6", reg_rdata, 8'h08);
      chk("R6", gates4(), held);
      chk("R6", {6'd0, mode_out}, 8'h03);
      ctx = "R7";
      step(0, 0, 0, 1, 0);
      chk("R7", {6'd0, osc_en, sys_clk_en}, 8'h02);
      step(0, 0, 0, 0, 0);
      chk("R7", {6'd0, pll_en, sys_clk_en}, 8'h02);
      step(0, 0, 0, 0, 0);
      chk("R7", {5'd0, sys_clk_en, clkout_en, core_halt}, 8'h06);
    end

    // R3 write lands on the same edge as the STOP strobe
    ctx = "R3";
    step(1, 8'hD8, 0, 0, 0);
    step(1, 8'h00, 1, 0, 0);
    chk("R3", {6'd0, mode_out}, 8'h03);
    chk("R3", gates4(), 8'h00);
    chk("R3", reg_rdata, 8'h00);
    repeat (3) step(0, 0, 0, (m_st == 1), 0);

    // R8 shallow mode returns in one edge
    ctx = "R8";
    step(1, 8'h58, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R8", {5'd0, core_halt, mode_out}, 8'h05);
    chk("R5", gates4(), 8'h0F);
    step(0, 0, 0, 1, 0);
    chk("R8", {5'd0, core_halt, mode_out}, 8'h00);

    // R9 ignored strobes
    ctx = "R9";
    step(0, 0, 0, 1, 0);
    chk("R9", {5'd0, core_halt, mode_out}, 8'h00);
    step(1, 8'h50, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(1, 8'hD8, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R9", {6'd0, mode_out}, 8'h01);
    chk("R9", gates4(), 8'h0F);
    step(0, 0, 0, 1, 0);

    // R10 regulator selection
    ctx = "R10";
    lvd_en = 1;
    step(1, 8'h02, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    chk("R10", {7'd0, vreg_pseudo}, 8'h01);
    lvd_en = 0;
    step(0, 0, 0, 0, 1);
    chk("R10", {7'd0, vreg_pseudo}, 8'h00);
    lvd_en = 1;
    step(0, 0, 0, 0, 0);
    chk("R10", {7'd0, vreg_pseudo}, 8'h00);
    step(0, 0, 0, 0, 1);
    step(1, 8'h00, 0, 0, 0);
    chk("R10", {7'd0, vreg_pseudo}, 8'h01);

    // Random phase against the model
    ctx = "random";
    for (int k = 0; k < 4000; k++) begin
      wd = 8'($urandom);
      if ($urandom % 2 == 0) wd[7:6] = 2'b11;
      if ($urandom % 16 == 0) lvd_en = ~lvd_en;
      step(($urandom % 4) == 0, wd, ($urandom % 6) == 0,
           ($urandom % 5) == 0, ($urandom % 8) == 0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule